// File: doc/BRIEF.md
# Serial Decimal-Digit to Binary Accumulator

This block turns a decimal number, presented one BCD digit per clock, into an unsigned 16-bit binary value. The most significant digit comes first. Each cycle in which the strobe is high, the block multiplies the stored value by ten and adds the incoming digit. The multiply by ten is built from fixed wiring: one copy of the value shifted left by three, another shifted left by one, and both summed. No multiplier is used.

A sticky fault flag marks a conversion that went wrong. It sets when an incoming digit is above nine, or when the new value would not fit in 16 bits. When a strobed digit causes a fault, the stored value stays as it was. The flag stays set until a synchronous reset, which also clears the value to zero before the next number is entered.

Top module: `bcd_serial_acc`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears the value output to 0 and the fault flag to 0.
- R2: On a rising edge where strobe is high, the digit (4 bits, binary-coded 0..9) is valid, and the value times ten plus the digit is at most 65535, the value output becomes that result after that edge.
- R3: On a rising edge where strobe is low, value and fault keep their previous values.
- R4: Digits enter most significant first: strobing 1, 2, 3 after reset yields 123 (binary 1111011).
- R5: A strobed digit code from 10 to 15 sets the fault flag and leaves the value unchanged.
- R6: A strobed digit whose result value times ten plus digit exceeds 65535 sets the fault flag and leaves the value unchanged. A result of exactly 65535 is accepted.
- R7: Once set, the fault flag stays high until reset, whatever later digits arrive. Later valid digits still update the value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| digit | input | 4 | BCD digit to append |
| strobe | input | 1 | Appends digit on this edge |
| value | output | 16 | Current accumulated binary value |
| fault | output | 1 | Sticky invalid-digit or overflow flag |

## Verification
A wrong accumulator value shows at the value port right after the edge that corrupted it. It then spreads through every later digit, because each step scales the stored value by ten. A bad overflow or validity decision shows up at once in two places: a fault flag that rises when it should not, or fails to rise, and a value that moves when it should hold. Holding random numbers of five digits near the 65535 limit tests the boundary compare on the edge where the fault flag is set.

// File: rtl/bcd_serial_acc.sv
module bcd_serial_acc #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [3:0]   digit,
  input  logic         strobe,
  output logic [W-1:0] value,
  output logic         fault
);
  localparam int XW = W + 4;

  logic [XW-1:0] times_ten;
  logic [XW-1:0] next_sum;
  logic          bad_digit;
  logic          too_big;
  logic          reject;

  assign times_ten = ({4'b0, value} << 3) + ({4'b0, value} << 1);
  assign next_sum  = times_ten + {{(XW-4){1'b0}}, digit};
  assign bad_digit = digit > 4'd9;
  assign too_big   = |next_sum[XW-1:W];
  assign reject    = bad_digit || too_big;

  always_ff @(posedge clk) begin
    if (rst) begin
      value <= '0;
      fault <= 1'b0;
    end else if (strobe) begin
      if (reject) fault <= 1'b1;
      else        value <= next_sum[W-1:0];
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (value == '0 && !fault)); // R1
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst) !strobe |=> ($stable(value) && $stable(fault))); // R3
  AST_BAD_DIGIT: assert property (@(posedge clk) disable iff (rst) (strobe && digit > 4'd9) |=> (fault && $stable(value))); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) (strobe && ({4'b0, value} * 10 + digit) > 65535) |=> (fault && $stable(value))); // R6
  AST_STICKY: assert property (@(posedge clk) disable iff (rst) fault |=> fault); // R7
endmodule

// File: tb/tb_bcd_serial_acc.sv
module tb_bcd_serial_acc;
  logic        clk = 0;
  logic        rst = 1;
  logic [3:0]  digit = 0;
  logic        strobe = 0;
  logic [15:0] value;
  logic        fault;
  int errors = 0, checks = 0;
  int unsigned mv;
  bit          mf;

  bcd_serial_acc dut (.clk(clk), .rst(rst), .digit(digit), .strobe(strobe), .value(value), .fault(fault));

  always #5 clk = ~clk;

  function automatic bit step_bad(input int unsigned v, input int unsigned d);
    return (d > 9) || (v * 10 + d > 65535);
  endfunction

  task automatic chk(input string req, input int unsigned exp_v, input bit exp_f);
    checks++;
    if (value !== exp_v[15:0] || fault !== exp_f) begin
      errors++;
      $display("FAIL %s value=%0d fault=%0b expected value=%0d fault=%0b", req, value, fault, exp_v, exp_f);
    end
  endtask

  task automatic do_reset();
    rst = 1; strobe = 0;
    @(posedge clk); #1;
    rst = 0; mv = 0; mf = 0;
  endtask

  task automatic send(input int unsigned d, input bit s);
    digit = d[3:0]; strobe = s;
    @(posedge clk); #1;
    strobe = 0;
    if (s) begin
      if (step_bad(mv, d)) mf = 1;
      else mv = mv * 10 + d;
    end
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    chk("R1", 0, 0);
    send(1, 1); send(2, 1); send(3, 1);
    chk("R4", 123, 0);
    send(7, 0); chk("R3", 123, 0);
    send(4, 1); chk("R2", 1234, 0);
    send(12, 1); chk("R5", 1234, 1);
    send(5, 1); chk("R7", 12345, 1);
    do_reset(); chk("R1", 0, 0);
    send(6, 1); send(5, 1); send(5, 1); send(3, 1); send(5, 1);
    chk("R6 exact 65535", 65535, 0);
    do_reset();
    send(6, 1); send(5, 1); send(5, 1); send(3, 1); send(6, 1);
    chk("R6 65536", 6553, 1);
    send(0, 0); chk("R3 hold fault", 6553, 1);
    do_reset();
    send(7, 1); send(0, 1); send(0, 1); send(0, 1); send(0, 1);
    chk("R6 70000", 7000, 1);
    for (int n = 0; n < 300; n++) begin
      do_reset();
      for (int k = 0; k < 5; k++) begin
        int unsigned d;
        bit s;
        d = ($urandom % 20 == 0) ? 10 + $urandom % 6 : $urandom % 10;
        s = ($urandom % 5) != 0;
        send(d, s);
        chk("R2", mv, mf);
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule